// File: doc/BRIEF.md
# Staged Selector Command Decoder

This block turns command bytes, delivered one per word by a serial front end, into the controls of three three-input selectors and two general-purpose logic levels. Each command byte carries an element code, a data bit and two fixed marker bits. A command first changes only a hidden pending copy of the state. The live outputs take the whole pending copy at once, on a word whose load bit is set. Several elements can therefore be reconfigured and switched together in a single step.

A word whose reset bit is clear, or an active-low system reset, opens every switch and drives both levels low, in both the pending and the live copy. The block also builds a 16-bit readback word from the live state. The serial protocol and the analog switch timing belong to other blocks.

Top module: `stagedSelectorTop`

## Requirements
- R1: A command byte is accepted only when bit 6 is 1 and bit 5 is 0. Bits 4..0 hold the element code and bit 7 holds the data bit (1 = on or high). A byte with any other marker pattern changes nothing.
- R2: Codes 0, 1 and 2 act on input A, B or C of all three selectors together. With data 1 they close that input; with data 0 they open it.
- R3: Codes 4..6, 8..10 and 12..14 act on input A, B or C of selector 1, 2 or 3 respectively. Data 1 closes the input and data 0 opens it.
- R4: Codes 0x10, 0x11 and 0x12 open every input of selector 1, 2 or 3. Code 0x1F opens all nine switches. The data bit has no effect on these codes.
- R5: Code 0x13 sets level 1, code 0x14 sets level 2 and code 0x15 sets both, each to the data bit.
- R6: Within one selector at most one input is closed. Closing an input opens the other two inputs of that selector.
- R7: When several staged commands touch the same element, the last one decides its state.
- R8: A word with the load bit clear (and the reset bit set) changes only the pending state. A word with the load bit set applies its own command and then copies the whole pending state to the live outputs at the same clock edge.
- R9: A word with the reset bit clear, or rstN low, opens all switches and drives both levels low in both the pending and the live state. The command byte of such a word is ignored.
- R10: Status bits 15..13 report selector 1 inputs A, B and C, bits 11..9 report selector 2 and bits 7..5 report selector 3 (1 = closed). Bit 3 reports level 1 and bit 2 reports level 2. All other status bits read 0.
- R11: Reserved codes (3, 7, 11, 15 and 0x16..0x1E) leave the pending state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | One-cycle strobe that marks a received 16-bit word |
| cmdByte | input | 8 | Command byte: data bit 7, marker bits 6..5, element code 4..0 |
| loadBit | input | 1 | Load bit of the word: copies the pending state to the live outputs |
| resetBit | input | 1 | Reset bit of the word: a clear bit resets the whole state |
| swEn | output | 9 | Live switch enables, index 3*selector + input (A=0, B=1, C=2) |
| gpo | output | 2 | Live general-purpose levels (bit 0 = level 1) |
| statusWord | output | 16 | Readback word built from the live state |

## Verification
The bench aims at the staging boundary. It sends commands without a load and checks that the outputs stay where they were, so a design that let commands through at once fails there. It then sends a load word with a reserved code, so a design that dropped the pending copy, or that treated the reserved code as a command, shows the wrong switches. Chains of commands on one element catch a design that merges commands instead of letting the last one win. Closing a second input of a selector catches an encoder that leaves two inputs closed. Bytes with wrong marker bits, disable codes carrying data 1, and a reset word followed by a bare load check that filtering and the clearing of the pending state are both correct.

// File: rtl/stagedSelectorPkg.sv
package stagedSelectorPkg;
  localparam int NUM_MUX    = 3;
  localparam int IN_PER_MUX = 3;
  localparam int NUM_GPO    = 2;
  localparam int CODE_W     = 5;
  localparam int NUM_SW     = NUM_MUX * IN_PER_MUX;
  localparam int STATUS_W   = 16;

  typedef logic [IN_PER_MUX-1:0] muxRow_t;
  typedef muxRow_t [NUM_MUX-1:0] swArr_t;

  // Strobes from command control to the state datapath.
  typedef struct packed {
    logic                stage;
    logic                commit;
    logic                clearAll;
    swArr_t              setOn;
    swArr_t              clrMask;
    logic [NUM_GPO-1:0]  gpoWe;
    logic                gpoVal;
  } cmdStrobes_t;
endpackage

// File: rtl/stagedSelectorCtrl.sv
module stagedSelectorCtrl
  import stagedSelectorPkg::*;
(
  input  logic        wordValid,
  input  logic [7:0]  cmdByte,
  input  logic        loadBit,
  input  logic        resetBit,
  output cmdStrobes_t strobes
);
  localparam logic [CODE_W-1:0] CODE_DIS_BASE = 5'h10;
  localparam logic [CODE_W-1:0] CODE_GPO1     = 5'h13;
  localparam logic [CODE_W-1:0] CODE_GPO2     = 5'h14;
  localparam logic [CODE_W-1:0] CODE_GPOBOTH  = 5'h15;
  localparam logic [CODE_W-1:0] CODE_ALLOFF   = 5'h1F;

  logic              markerOk;
  logic              dataBit;
  logic [CODE_W-1:0] code;
  logic [1:0]        inSel;
  logic [1:0]        grpSel;

  assign markerOk = cmdByte[6] & ~cmdByte[5];
  assign dataBit  = cmdByte[7];
  assign code     = cmdByte[CODE_W-1:0];
  assign inSel    = code[1:0];
  assign grpSel   = code[3:2];

  always_comb begin
    strobes          = '0;
    strobes.clearAll = wordValid & ~resetBit;
    strobes.stage    = wordValid & resetBit;
    strobes.commit   = wordValid & resetBit & loadBit;
    strobes.gpoVal   = dataBit;
    if (wordValid && resetBit && markerOk) begin
      if (!code[4] && inSel != 2'd3) begin
        for (int m = 0; m < NUM_MUX; m++) begin
          // group codes (grpSel 0) hit every selector, others hit one
          if (grpSel == 2'd0 || int'(grpSel) == m + 1) begin
            if (dataBit) strobes.setOn[m][inSel]   = 1'b1;
            else         strobes.clrMask[m][inSel] = 1'b1;
          end
        end
      end else if (code == CODE_ALLOFF) begin
        strobes.clrMask = '1;
      end else if (code >= CODE_DIS_BASE && code < CODE_GPO1) begin
        for (int m = 0; m < NUM_MUX; m++)
          if (int'(code - CODE_DIS_BASE) == m) strobes.clrMask[m] = '1;
      end else if (code == CODE_GPO1) begin
        strobes.gpoWe = 2'b01;
      end else if (code == CODE_GPO2) begin
        strobes.gpoWe = 2'b10;
      end else if (code == CODE_GPOBOTH) begin
        strobes.gpoWe = 2'b11;
      end
    end
  end
endmodule

// File: rtl/stagedSelectorData.sv
module stagedSelectorData
  import stagedSelectorPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cmdStrobes_t        strobes,
  output swArr_t             liveSw,
  output logic [NUM_GPO-1:0] liveGpo
);
  swArr_t             pendSw, nextSw;
  logic [NUM_GPO-1:0] pendGpo, nextGpo;

  always_comb begin
    for (int m = 0; m < NUM_MUX; m++) begin
      if (|strobes.setOn[m]) nextSw[m] = strobes.setOn[m];
      else                   nextSw[m] = pendSw[m] & ~strobes.clrMask[m];
    end
    for (int g = 0; g < NUM_GPO; g++)
      nextGpo[g] = strobes.gpoWe[g] ? strobes.gpoVal : pendGpo[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      pendSw  <= '0;
      pendGpo <= '0;
      liveSw  <= '0;
      liveGpo <= '0;
    end else if (strobes.stage) begin
      pendSw  <= nextSw;
      pendGpo <= nextGpo;
      if (strobes.commit) begin
        liveSw  <= nextSw;
        liveGpo <= nextGpo;
      end
    end
  end
endmodule

// File: rtl/stagedSelectorTop.sv
module stagedSelectorTop
  import stagedSelectorPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic [7:0]  cmdByte,
  input  logic        loadBit,
  input  logic        resetBit,
  output logic [8:0]  swEn,
  output logic [1:0]  gpo,
  output logic [15:0] statusWord
);
  cmdStrobes_t        strobes;
  swArr_t             liveSw;
  logic [NUM_GPO-1:0] liveGpo;

  stagedSelectorCtrl uCtrl (
    .wordValid(wordValid),
    .cmdByte  (cmdByte),
    .loadBit  (loadBit),
    .resetBit (resetBit),
    .strobes  (strobes)
  );

  stagedSelectorData uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .liveSw (liveSw),
    .liveGpo(liveGpo)
  );

  assign gpo = liveGpo;

  always_comb begin
    statusWord = '0;
    for (int m = 0; m < NUM_MUX; m++)
      for (int i = 0; i < IN_PER_MUX; i++) begin
        swEn[m*IN_PER_MUX + i]       = liveSw[m][i];
        statusWord[STATUS_W-1-4*m-i] = liveSw[m][i];
      end
    for (int g = 0; g < NUM_GPO; g++)
      statusWord[3-g] = liveGpo[g];
  end
endmodule

// File: rtl/stagedSelectorChecker.sv
module stagedSelectorChecker (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic        loadBit,
  input logic        resetBit,
  input logic [8:0]  swEn,
  input logic [1:0]  gpo,
  input logic [15:0] statusWord
);
  genvar m;
  generate
    for (m = 0; m < 3; m++) begin : gOneHot
      a_r6_one_per_mux: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(swEn[3*m +: 3]));
      a_r10_mux_field: assert property (@(posedge clk) disable iff (!rstN)
        statusWord[15-4*m] == swEn[3*m] && statusWord[14-4*m] == swEn[3*m+1] &&
        statusWord[13-4*m] == swEn[3*m+2]);
    end
  endgenerate

  a_r9_reset_word_clears: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !resetBit |=> swEn == '0 && gpo == '0);

  a_r8_hold_without_load: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && (loadBit || !resetBit)) |=> $stable(swEn) && $stable(gpo));

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & 16'h1113) == 16'h0000);

  a_r10_gpo_field: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[3] == gpo[0] && statusWord[2] == gpo[1]);
endmodule

bind stagedSelectorTop stagedSelectorChecker uChecker (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .loadBit(loadBit),
  .resetBit(resetBit), .swEn(swEn), .gpo(gpo), .statusWord(statusWord)
);

// File: tb/tb_stagedSelectorTop.sv
module tb_stagedSelectorTop;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic        loadBit = 1'b0;
  logic        resetBit = 1'b1;
  logic [8:0]  swEn;
  logic [1:0]  gpo;
  logic [15:0] statusWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench reference: pending and live copies, index 3*selector+input
  logic [8:0] pSw = '0, lSw = '0;
  logic [1:0] pG = '0, lG = '0;

  stagedSelectorTop dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .cmdByte(cmdByte),
    .loadBit(loadBit), .resetBit(resetBit), .swEn(swEn), .gpo(gpo),
    .statusWord(statusWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expStatus(logic [8:0] s, logic [1:0] g);
    logic [15:0] r = '0;
    r[15] = s[0]; r[14] = s[1]; r[13] = s[2];
    r[11] = s[3]; r[10] = s[4]; r[9]  = s[5];
    r[7]  = s[6]; r[6]  = s[7]; r[5]  = s[8];
    r[3]  = g[0]; r[2]  = g[1];
    return r;
  endfunction

  task automatic closeIn(int mx, int in);
    for (int k = 0; k < 3; k++) pSw[3*mx+k] = (k == in);
  endtask

  task automatic modelCmd(logic [7:0] b);
    logic d = b[7];
    int c = int'(b[4:0]);
    if (b[6:5] != 2'b10) return;
    if (c <= 2) begin
      for (int mx = 0; mx < 3; mx++)
        if (d) closeIn(mx, c); else pSw[3*mx+c] = 1'b0;
    end else if (c >= 4 && c <= 14 && (c % 4) != 3) begin
      if (d) closeIn(c/4 - 1, c%4); else pSw[3*(c/4-1) + c%4] = 1'b0;
    end else if (c >= 16 && c <= 18) begin
      for (int k = 0; k < 3; k++) pSw[3*(c-16)+k] = 1'b0;
    end else if (c == 31) pSw = '0;
    else if (c == 19) pG[0] = d;
    else if (c == 20) pG[1] = d;
    else if (c == 21) pG = {d, d};
  endtask

  task automatic check(string tag);
    logic [15:0] es = expStatus(lSw, lG);
    total++;
    if (swEn !== lSw || gpo !== lG || statusWord !== es) begin
      bad++;
      $display("FAIL %s: sw=%b gpo=%b st=%h expected sw=%b gpo=%b st=%h",
               tag, swEn, gpo, statusWord, lSw, lG, es);
    end
  endtask

  task automatic sendWord(logic [7:0] b, logic ld, logic rs, string tag);
    @(negedge clk);
    cmdByte = b; loadBit = ld; resetBit = rs; wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0;
    if (!rs) begin pSw = '0; pG = '0; lSw = '0; lG = '0; end
    else begin
      modelCmd(b);
      if (ld) begin lSw = pSw; lG = pG; end
    end
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 power-up state");

    sendWord(8'hC4, 1'b0, 1'b1, "R8 staged only");
    sendWord(8'h43, 1'b1, 1'b1, "R8 R11 load with reserved code");
    sendWord(8'hC5, 1'b1, 1'b1, "R6 close B opens A");
    sendWord(8'hCA, 1'b0, 1'b1, "R7 stage C");
    sendWord(8'h4A, 1'b0, 1'b1, "R7 stage C off");
    sendWord(8'hC9, 1'b1, 1'b1, "R7 last wins B");
    sendWord(8'hC0, 1'b1, 1'b1, "R2 group A on");
    sendWord(8'h42, 1'b1, 1'b1, "R2 group C off");
    sendWord(8'h4C, 1'b1, 1'b1, "R3 selector 3 A off");
    sendWord(8'hCE, 1'b1, 1'b1, "R3 selector 3 C on");
    sendWord(8'hD0, 1'b1, 1'b1, "R4 disable selector 1 with data 1");
    sendWord(8'hD3, 1'b1, 1'b1, "R5 level 1 high");
    sendWord(8'hD5, 1'b1, 1'b1, "R5 both high");
    sendWord(8'h54, 1'b1, 1'b1, "R5 level 2 low");
    sendWord(8'hE1, 1'b1, 1'b1, "R1 marker 11 ignored");
    sendWord(8'h81, 1'b1, 1'b1, "R1 marker 00 ignored");
    sendWord(8'hCF, 1'b1, 1'b1, "R11 code 15 reserved");
    sendWord(8'hDA, 1'b1, 1'b1, "R11 code 0x1A reserved");
    sendWord(8'h5F, 1'b1, 1'b1, "R4 all off");
    sendWord(8'hC8, 1'b0, 1'b1, "R9 stage before reset word");
    sendWord(8'hC4, 1'b1, 1'b0, "R9 reset word clears");
    sendWord(8'h43, 1'b1, 1'b1, "R9 pending cleared too");

    for (int n = 0; n < 600; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if ($urandom_range(0, 9) != 0) b[6:5] = 2'b10;
      sendWord(b, $urandom_range(0, 2) == 0, $urandom_range(0, 29) != 0,
               "R1 R2 R3 R4 R5 R6 R7 R8 R10 R11 random");
    end

    sendWord(8'hC6, 1'b1, 1'b1, "R10 before system reset");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    pSw = '0; pG = '0; lSw = '0; lG = '0;
    check("R9 system reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule